// File: doc/BRIEF.md
# Indirect Coefficient Memory Access Port

This block gives a host processor load and read-back access to the parameter store of a multi-channel filter. It holds two separate memories. The gain memory keeps 32-bit coefficients. The shift memory keeps 5-bit shift amounts. Neither memory is mapped directly onto the bus. Each memory sits behind a pair of 32-bit registers: a control register and a data register.

To reach a memory, the host first writes the control register. That write sets a start location, picks the transfer direction and says whether the pointer advances after each access. The host then moves words through the data register, one bus access per word. Bus reads complete in the same cycle with no wait states.

The default sizing stores eight channels. Each channel has 62 gain words and 14 shift words, and channel n begins at n times the per-channel size. A read of the data register can move the pointer, so software must not issue it speculatively.

Top module: `coef_seq_port`

## Requirements
- R1: After reset both control registers read 0x00004000: sequential mode on, read direction, location 0.
- R2: The four registers are decoded from byte address bits [3:2]: gain control at 0x00, gain data at 0x04, shift control at 0x08, shift data at 0x0C. Address bits [1:0] are ignored. Any byte address at 0x10 or above reads 0, and writes to it have no effect.
- R3: A control write with bit 13 (load) set loads the bank pointer from bits [11:0], taken modulo the bank depth. A control write with bit 13 clear leaves the pointer where it was.
- R4: With bit 14 (sequential) set, each accepted data access moves the pointer to the next location. The location after depth-1 is location 0.
- R5: With bit 14 clear, the pointer stays put after data accesses. Repeated reads return the same word, and repeated writes replace the same word.
- R6: With bit 12 clear (read direction), a data-register read returns the word at the pointer in the same cycle.
- R7: With bit 12 set (write direction), a data-register write stores the bus word at the pointer. The shift memory keeps only bits [4:0] and reads back zeros above them.
- R8: An access against the selected direction is ignored. A data write in read direction stores nothing, and a data read in write direction returns 0. Neither moves the pointer.
- R9: The gain memory holds 496 words (8 channels × 62) and the shift memory holds 112 words (8 × 14). Each has its own pointer, and an access to one never changes the other.
- R10: A control register reads back bits 14, 12 and [11:0] as last written. Bit 13 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |

## Verification
A wrong pointer shows up at the data register. It appears on the first read after the fault, as a word from the neighbouring location or from a wrapped location. A fault in the load, advance or wrap logic is therefore seen within one access of the control write that sets up the transfer. A direction or masking fault corrupts stored words. It appears only when those words are read back, so every write run in the bench is followed by a read run over the same locations.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int BUS_W     = 32;
  localparam int LOC_W     = 12;   // location field width in a control word
  localparam int DIR_BIT   = 12;   // 1 = write direction
  localparam int LOAD_BIT  = 13;   // load pointer from location field
  localparam int SEQ_BIT   = 14;   // advance pointer after each data access
  localparam int N_BANKS   = 2;
  localparam int BANK_GAIN = 0;
  localparam int BANK_SHFT = 1;
  localparam logic [BUS_W-1:0] CTRL_RESET = 32'h0000_4000;

  typedef struct packed {
    logic             seq;
    logic             dir_wr;
    logic [LOC_W-1:0] loc;
  } bank_ctrl_t;
endpackage

// File: rtl/coef_bus_decode.sv
module coef_bus_decode
  import coef_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  ctrl_rd [N_BANKS],
  input  logic [BUS_W-1:0]  data_rd [N_BANKS],
  output logic [N_BANKS-1:0] ctrl_wr,
  output logic [N_BANKS-1:0] data_acc,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic       hit;
  logic       is_data;
  logic       bank;

  assign hit     = (bus_addr[ADDR_W-1:4] == '0);
  assign is_data = bus_addr[2];
  assign bank    = bus_addr[3];

  always_comb begin
    ctrl_wr   = '0;
    data_acc  = '0;
    bus_rdata = '0;
    if (bus_en && hit) begin
      if (is_data) data_acc[bank] = 1'b1;
      else if (bus_we) ctrl_wr[bank] = 1'b1;
      if (!bus_we) bus_rdata = is_data ? data_rd[bank] : ctrl_rd[bank];
    end
  end

  // R2: at most one register strobe per bus cycle
  always_comb begin
    a_r2_one_target: assert ($onehot0({ctrl_wr, data_acc}));
  end
endmodule

// File: rtl/coef_bank.sv
module coef_bank
  import coef_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 496
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             data_acc,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] ctrl_rd,
  output logic [BUS_W-1:0] data_rd
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  bank_ctrl_t          ctrl_q;
  logic [PTR_W-1:0]    ptr;
  logic [DATA_W-1:0]   mem [DEPTH];
  logic                acc_ok;
  logic [PTR_W-1:0]    ptr_next;
  logic [PTR_W-1:0]    load_ptr;

  function automatic logic [PTR_W-1:0] wrap_loc(input logic [LOC_W-1:0] a);
    return PTR_W'(32'(a) % DEPTH);
  endfunction

  assign acc_ok   = data_acc && (bus_we == ctrl_q.dir_wr);
  assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign load_ptr = wrap_loc(wdata[LOC_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= bank_ctrl_t'({CTRL_RESET[SEQ_BIT], CTRL_RESET[DIR_BIT],
                              CTRL_RESET[LOC_W-1:0]});
      ptr    <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.seq    <= wdata[SEQ_BIT];
      ctrl_q.dir_wr <= wdata[DIR_BIT];
      ctrl_q.loc    <= wdata[LOC_W-1:0];
      if (wdata[LOAD_BIT]) ptr <= load_ptr;
    end else if (acc_ok && ctrl_q.seq) begin
      ptr <= ptr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_ok && bus_we) mem[ptr] <= wdata[DATA_W-1:0];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[SEQ_BIT]   = ctrl_q.seq;
    ctrl_rd[DIR_BIT]   = ctrl_q.dir_wr;
    ctrl_rd[LOC_W-1:0] = ctrl_q.loc;
    data_rd = '0;
    if (!ctrl_q.dir_wr) data_rd[DATA_W-1:0] = mem[ptr];
  end

  // R3: load bit places the pointer at the wrapped location
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata[LOAD_BIT] |=> ptr == wrap_loc($past(wdata[LOC_W-1:0])));
  // R3: control write without load keeps the pointer
  a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !wdata[LOAD_BIT] |=> $stable(ptr));
  // R4: sequential step with wrap
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && ctrl_q.seq |=>
      ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
  // R5: no step when sequential mode is off
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !ctrl_q.seq |=> $stable(ptr));
  // R8: wrong-direction access leaves the pointer
  a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && (bus_we != ctrl_q.dir_wr) |=> $stable(ptr));
  // R9: pointer never leaves the bank
  a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) < DEPTH);
endmodule

// File: rtl/coef_seq_port.sv
module coef_seq_port
  import coef_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int N_CHAN      = 8,
  parameter int GAIN_PER_CH = 62,
  parameter int SHFT_PER_CH = 14,
  parameter int GAIN_W      = 32,
  parameter int SHFT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int GAIN_DEPTH = N_CHAN * GAIN_PER_CH;
  localparam int SHFT_DEPTH = N_CHAN * SHFT_PER_CH;

  logic [N_BANKS-1:0] ctrl_wr;
  logic [N_BANKS-1:0] data_acc;
  logic [BUS_W-1:0]   ctrl_rd [N_BANKS];
  logic [BUS_W-1:0]   data_rd [N_BANKS];

  coef_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .ctrl_rd   (ctrl_rd),
    .data_rd   (data_rd),
    .ctrl_wr   (ctrl_wr),
    .data_acc  (data_acc),
    .bus_rdata (bus_rdata)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam int W = (b == BANK_GAIN) ? GAIN_W : SHFT_W;
    localparam int D = (b == BANK_GAIN) ? GAIN_DEPTH : SHFT_DEPTH;
    coef_bank #(.DATA_W(W), .DEPTH(D)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (ctrl_wr[b]),
      .data_acc (data_acc[b]),
      .bus_we   (bus_we),
      .wdata    (bus_wdata),
      .ctrl_rd  (ctrl_rd[b]),
      .data_rd  (data_rd[b])
    );
  end
endmodule

// File: tb/tb_coef_seq_port.sv
module tb_coef_seq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [5:0] GC = 6'h00, GD = 6'h04, SC = 6'h08, SD = 6'h0C;

  coef_seq_port dut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #5 d = bus_rdata;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(GC, v); check("R1 gain ctrl", v, 32'h4000);
    rd(SC, v); check("R1 shift ctrl", v, 32'h4000);
    rd(6'h02, v); check("R2 low bits ignored", v, 32'h4000);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, v); check("R2 unmapped read", v, 0);
    rd(GC, v); check("R2 unmapped write no effect", v, 32'h4000);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(GC, 32'h0000_7005);
    rd(GC, v); check("R10 ctrl readback", v, 32'h0000_5005);
  endtask

  task automatic t_stream();
    logic [31:0] v;
    wr(GC, 32'h7000 | 434);           // channel 7 base
    for (int i = 0; i < 3; i++) wr(GD, 32'hA5A5_0000 + i);
    wr(GC, 32'h6000 | 434);
    for (int i = 0; i < 3; i++) begin
      rd(GD, v); check("R6 R7 R4 stream read", v, 32'hA5A5_0000 + i);
    end
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(GC, 32'h7000 | 495);
    wr(GD, 32'h1111_1111);
    wr(GD, 32'h2222_2222);
    wr(GC, 32'h6000 | 495);
    rd(GD, v); check("R4 last location", v, 32'h1111_1111);
    rd(GD, v); check("R4 wrap to 0", v, 32'h2222_2222);
    wr(GC, 32'h6000);
    rd(GD, v); check("R9 location 0", v, 32'h2222_2222);
  endtask

  task automatic t_modulo();
    logic [31:0] v;
    wr(GC, 32'h7000 | 500);
    wr(GD, 32'hC0DE_0004);
    wr(GC, 32'h6004);
    rd(GD, v); check("R3 gain modulo", v, 32'hC0DE_0004);
    wr(SC, 32'h7000 | 120);
    wr(SD, 32'hFFFF_FFF3);
    wr(SC, 32'h6008);
    rd(SD, v); check("R7 R3 shift mask and modulo", v, 32'h13);
  endtask

  task automatic t_noseq();
    logic [31:0] v;
    wr(GC, 32'h3000 | 10);
    wr(GD, 32'hDDDD_0001);
    wr(GD, 32'hEEEE_0002);
    wr(GC, 32'h2000 | 10);
    rd(GD, v); check("R5 overwrite same word", v, 32'hEEEE_0002);
    rd(GD, v); check("R5 repeat read same word", v, 32'hEEEE_0002);
    wr(GC, 32'h4000 | 300);
    rd(GD, v); check("R3 no load keeps pointer", v, 32'hEEEE_0002);
  endtask

  task automatic t_wrong_dir();
    logic [31:0] v;
    wr(GC, 32'h7000 | 20);
    wr(GD, 32'hF0F0_F0F0);
    wr(GC, 32'h6000 | 20);
    wr(GD, 32'h0BAD_0BAD);
    rd(GD, v); check("R8 write in read mode ignored", v, 32'hF0F0_F0F0);
    wr(GC, 32'h7000 | 20);
    rd(GD, v); check("R8 read in write mode gives 0", v, 0);
    wr(GD, 32'h6060_6060);
    wr(GC, 32'h6000 | 20);
    rd(GD, v); check("R8 read did not advance", v, 32'h6060_6060);
  endtask

  task automatic t_independent();
    logic [31:0] v;
    wr(SC, 32'h7000);
    wr(SD, 32'h5);
    wr(GC, 32'h7000);
    wr(GD, 32'h1234_5678);
    wr(SC, 32'h6000);
    rd(SD, v); check("R9 shift untouched by gain", v, 32'h5);
    wr(GC, 32'h6000);
    rd(GD, v); check("R9 gain word", v, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_readback();
    t_stream();
    t_wrap();
    t_modulo();
    t_noseq();
    t_wrong_dir();
    t_independent();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule